// File: doc/BRIEF.md
# Flash Controller with Erase Sequencer

This block sits between a 32-bit register bus and the write side of an on-chip code flash array. Software reads a status word and sets a two-bit configuration value that the array uses as write enable and erase enable. Software also writes command registers that erase one page or the whole code space. An erase is carried out by a sequencer. It drives all-ones words into the array through a word-wide write port, one word per clock, and while it runs the ready bit reads 0.

The block also holds a 64-word user configuration area on a second, word-aligned port. Software reads and writes it freely. A reset, a dedicated erase command or the erase-all command sets every word back to all-ones. Page size and page count are parameters. A page smaller than the 256-byte user area is a configuration error and stops elaboration.

Top module: `flash_ctrl`

## Requirements
- R1: After reset, ready reads 1, the configuration register reads 0, no code write is issued, and every user-area word reads 0xFFFFFFFF.
- R2: A register read at offset 0x400 returns the value 1 in bit 0 when the sequencer is idle and 0 while it is busy. All other bits read 0.
- R3: A write to offset 0x504 stores only bits [1:0] (bit 0 write enable, bit 1 erase enable). A read of 0x504 returns the stored value, and the value also drives cfg_o.
- R4: A write to offset 0x508 or 0x510 clears the low log2(PAGE_BYTES) bits of the data to form a page address. If that page is in range, the block writes 0xFFFFFFFF to every word of the page, in ascending word address order, one word per cycle, starting the cycle after acceptance. The first word address is page times PAGE_BYTES/4.
- R5: A page-erase write whose aligned address is at or above NUM_PAGES*PAGE_BYTES is ignored. No code write takes place and ready stays 1.
- R6: A write of exactly 1 to offset 0x50C writes 0xFFFFFFFF to every code word from address 0 upward. One cycle after the last word, all user-area words are set to 0xFFFFFFFF. Any other data value is ignored.
- R7: A write of exactly 1 to offset 0x514 sets all user-area words to 0xFFFFFFFF, with ready at 0 for one cycle. Any other data value is ignored.
- R8: User-area accesses use a byte address. Only addresses with bits [1:0] equal to 0 and below 256 take effect. Other writes change nothing, and other reads return 0.
- R9: Reads of any other register offset return 0, and writes to them have no effect.
- R10: Erase commands written while ready is 0 are dropped. Register reads stay valid while an erase runs.
- R11: Ready goes to 0 in the cycle after an erase command is accepted. It returns to 1 only after the last word of the operation has been written (or after the user-area clear, for the commands that include it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access valid |
| reg_we_i | input | 1 | Register access is a write |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, same cycle |
| ua_req_i | input | 1 | User-area access valid |
| ua_we_i | input | 1 | User-area access is a write |
| ua_addr_i | input | 10 | User-area byte address |
| ua_wdata_i | input | 32 | User-area write data |
| ua_rdata_o | output | 32 | User-area read data, same cycle |
| cfg_o | output | 2 | Stored write enable (bit 0) and erase enable (bit 1) |
| code_we_o | output | 1 | Code array word write strobe |
| code_waddr_o | output | 16 | Code array word address |
| code_wdata_o | output | 32 | Code array write data |
| ready_o | output | 1 | Sequencer idle |

## Verification
A wrong sequencer pointer or end bound shows on the code write port in the very cycle it occurs. It appears as a skipped, repeated or out-of-page word address, or as a strobe that lasts one cycle too long or too short. The bench compares the write port and ready against its reference on every clock, so such faults are caught immediately. A lost or missing user-area clear shows only on the next user-area read. For that reason the bench reads a previously written word right after each clearing command completes, and after each ignored one.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFF_STATUS = 12'h400;
  localparam logic [REG_AW-1:0] OFF_CFG    = 12'h504;
  localparam logic [REG_AW-1:0] OFF_PG_A   = 12'h508;
  localparam logic [REG_AW-1:0] OFF_ALL    = 12'h50C;
  localparam logic [REG_AW-1:0] OFF_PG_B   = 12'h510;
  localparam logic [REG_AW-1:0] OFF_UERASE = 12'h514;

  typedef enum logic [1:0] {CMD_NONE, CMD_PAGE, CMD_ALL, CMD_USER} cmd_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WIPE, SQ_UCLR} seq_e;
endpackage

// File: rtl/flash_ctrl_regs.sv
module flash_ctrl_regs
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned NUM_PAGES  = 256,
  localparam int unsigned OFF_BITS  = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              ready_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        cfg_o,
  output cmd_e              cmd_o,
  output logic [PAGE_W-1:0] page_o
);
  logic [1:0]  cfg_q;
  logic        wr;
  logic [31:0] pg_idx;
  logic        pg_ok;

  assign wr     = req_i && we_i;
  assign pg_idx = wdata_i >> OFF_BITS;  // align down
  assign pg_ok  = pg_idx < 32'(NUM_PAGES);
  assign page_o = pg_idx[PAGE_W-1:0];
  assign cfg_o  = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cfg_q <= '0;
    else if (wr && addr_i == OFF_CFG) cfg_q <= wdata_i[1:0];
  end

  always_comb begin
    cmd_o = CMD_NONE;
    if (wr && ready_i) begin
      unique case (addr_i)
        OFF_PG_A, OFF_PG_B: if (pg_ok)        cmd_o = CMD_PAGE;
        OFF_ALL:            if (wdata_i == 1) cmd_o = CMD_ALL;
        OFF_UERASE:         if (wdata_i == 1) cmd_o = CMD_USER;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i) begin
      unique case (addr_i)
        OFF_STATUS: rdata_o = {31'b0, ready_i};
        OFF_CFG:    rdata_o = {30'b0, cfg_q};
        default: ;
      endcase
    end
  end

  p_cfg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == OFF_CFG) |=> $stable(cfg_o));
endmodule

// File: rtl/flash_ctrl_seq.sv
module flash_ctrl_seq
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned WPP       = 256,
  parameter int unsigned NUM_PAGES = 256,
  parameter int unsigned PAGE_W    = 8,
  localparam int unsigned WPP_BITS = $clog2(WPP),
  localparam int unsigned TOTAL    = WPP * NUM_PAGES,
  localparam int unsigned WADDR_W  = $clog2(TOTAL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cmd_e               cmd_i,
  input  logic [PAGE_W-1:0]  page_i,
  output logic               ready_o,
  output logic               we_o,
  output logic [WADDR_W-1:0] waddr_o,
  output logic [31:0]        wdata_o,
  output logic               uclr_o
);
  seq_e               st_q;
  logic [WADDR_W-1:0] ptr_q, last_q;
  logic               all_q;
  logic [WADDR_W-1:0] pg_base;

  assign pg_base = WADDR_W'({page_i, {WPP_BITS{1'b0}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      ptr_q  <= '0;
      last_q <= '0;
      all_q  <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          unique case (cmd_i)
            CMD_PAGE: begin
              st_q   <= SQ_WIPE;
              ptr_q  <= pg_base;
              last_q <= pg_base + WADDR_W'(WPP - 1);
              all_q  <= 1'b0;
            end
            CMD_ALL: begin
              st_q   <= SQ_WIPE;
              ptr_q  <= '0;
              last_q <= WADDR_W'(TOTAL - 1);
              all_q  <= 1'b1;
            end
            CMD_USER: st_q <= SQ_UCLR;
            default: ;
          endcase
        end
        SQ_WIPE: begin
          if (ptr_q == last_q) st_q <= all_q ? SQ_UCLR : SQ_IDLE;
          else                 ptr_q <= ptr_q + 1'b1;
        end
        SQ_UCLR: st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == SQ_IDLE);
  assign we_o    = (st_q == SQ_WIPE);
  assign waddr_o = ptr_q;
  assign wdata_o = '1;
  assign uclr_o  = (st_q == SQ_UCLR);

  p_ascend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && $past(we_o) |-> waddr_o == $past(waddr_o) + 1'b1);
  p_accept_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && cmd_i != CMD_NONE |=> !ready_o);
  p_all_then_uclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && all_q && ptr_q == last_q |=> uclr_o && !we_o);
  p_write_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> wdata_o == 32'hFFFF_FFFF && !ready_o);
endmodule

// File: rtl/flash_ctrl_uarea.sv
module flash_ctrl_uarea #(
  parameter int unsigned WORDS  = 64,
  parameter int unsigned AW     = 10,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          clr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0]      mem_q [WORDS];
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = req_i && (addr_i[1:0] == 2'b00) && (addr_i < AW'(WORDS * 4));
  assign idx = addr_i[IDX_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (clr_i) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (hit && we_i) begin
      mem_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = hit ? mem_q[idx] : '0;

  p_clr_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> mem_q[0] == 32'hFFFF_FFFF && mem_q[WORDS-1] == 32'hFFFF_FFFF);
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned NUM_PAGES  = 256,
  parameter int unsigned UA_WORDS   = 64,
  parameter int unsigned UA_AW      = 10,
  localparam int unsigned WPP       = PAGE_BYTES / 4,
  localparam int unsigned TOTAL     = WPP * NUM_PAGES,
  localparam int unsigned WADDR_W   = $clog2(TOTAL),
  localparam int unsigned PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               ua_req_i,
  input  logic               ua_we_i,
  input  logic [UA_AW-1:0]   ua_addr_i,
  input  logic [31:0]        ua_wdata_i,
  output logic [31:0]        ua_rdata_o,
  output logic [1:0]         cfg_o,
  output logic               code_we_o,
  output logic [WADDR_W-1:0] code_waddr_o,
  output logic [31:0]        code_wdata_o,
  output logic               ready_o
);
  initial begin : geom_check
    assert (PAGE_BYTES >= UA_WORDS * 4)
      else $fatal(1, "page size below user area size");
  end

  cmd_e              cmd;
  logic [PAGE_W-1:0] page;
  logic              uclr;

  flash_ctrl_regs #(
    .PAGE_BYTES(PAGE_BYTES),
    .NUM_PAGES (NUM_PAGES)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (reg_req_i),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .ready_i(ready_o),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg_o),
    .cmd_o  (cmd),
    .page_o (page)
  );

  flash_ctrl_seq #(
    .WPP      (WPP),
    .NUM_PAGES(NUM_PAGES),
    .PAGE_W   (PAGE_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .page_i (page),
    .ready_o(ready_o),
    .we_o   (code_we_o),
    .waddr_o(code_waddr_o),
    .wdata_o(code_wdata_o),
    .uclr_o (uclr)
  );

  flash_ctrl_uarea #(
    .WORDS(UA_WORDS),
    .AW   (UA_AW)
  ) u_uarea (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (ua_req_i),
    .we_i   (ua_we_i),
    .addr_i (ua_addr_i),
    .wdata_i(ua_wdata_i),
    .clr_i  (uclr),
    .rdata_o(ua_rdata_o)
  );

  p_drop_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_we_o && $past(code_we_o) |-> !ready_o);
endmodule

// File: tb/tb_flash_ctrl.sv
module tb_flash_ctrl;
  localparam int PB  = 256;
  localparam int NP  = 4;
  localparam int WPP = PB / 4;
  localparam int TOT = NP * WPP;
  localparam int AW  = $clog2(TOT);
  localparam int UW  = 64;
  localparam int UAW = 10;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            reg_req = 0, reg_we = 0;
  logic [11:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            ua_req = 0, ua_we = 0;
  logic [UAW-1:0]  ua_addr = '0;
  logic [31:0]     ua_wdata = '0;
  logic [31:0]     ua_rdata;
  logic [1:0]      cfg;
  logic            code_we;
  logic [AW-1:0]   code_waddr;
  logic [31:0]     code_wdata;
  logic            ready;

  always #4 clk = ~clk;

  flash_ctrl #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .UA_WORDS(UW), .UA_AW(UAW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ua_req_i(ua_req), .ua_we_i(ua_we), .ua_addr_i(ua_addr),
    .ua_wdata_i(ua_wdata), .ua_rdata_o(ua_rdata),
    .cfg_o(cfg), .code_we_o(code_we), .code_waddr_o(code_waddr),
    .code_wdata_o(code_wdata), .ready_o(ready)
  );

  int n_tests = 0, n_fail = 0;
  int q[$];
  bit m_pend = 0, m_clr_now = 0, m_busy = 0;
  logic [1:0]  m_cfg = '0;
  logic [31:0] m_ua [UW];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial for (int i = 0; i < UW; i++) m_ua[i] = '1;

  // reference model: command acceptance and storage updates at the clock edge
  always @(posedge clk) if (rst_ni) begin
    if (reg_req && reg_we) begin
      case (reg_addr)
        12'h504: m_cfg = reg_wdata[1:0];
        12'h508, 12'h510:
          if (!m_busy && (reg_wdata / PB) < NP)
            for (int k = 0; k < WPP; k++) q.push_back(int'(reg_wdata / PB) * WPP + k);
        12'h50C:
          if (!m_busy && reg_wdata == 1) begin
            for (int k = 0; k < TOT; k++) q.push_back(k);
            m_pend = 1;
          end
        12'h514: if (!m_busy && reg_wdata == 1) m_pend = 1;
        default: ;
      endcase
    end
    if (ua_req && ua_we && ua_addr[1:0] == 0 && ua_addr < UW * 4) m_ua[ua_addr / 4] = ua_wdata;
    if (m_clr_now) begin
      for (int i = 0; i < UW; i++) m_ua[i] = '1;
      m_clr_now = 0;
    end
  end

  // per-cycle comparison of write port and ready (R4, R6, R11)
  always @(negedge clk) if (rst_ni) begin
    #2;
    if (q.size() > 0) begin
      m_busy = 1;
      chk(code_we && !ready && code_wdata == 32'hFFFF_FFFF && int'(code_waddr) == q[0],
          "R11/R4 write port", {code_we, ready, 22'b0, code_waddr}, {2'b10, 22'b0, AW'(q[0])});
      void'(q.pop_front());
    end else if (m_pend) begin
      m_busy = 1;
      chk(!code_we && !ready, "R11/R6 user clear cycle", {30'b0, code_we, ready}, 32'h0);
      m_pend = 0;
      m_clr_now = 1;
    end else begin
      m_busy = 0;
      chk(!code_we && ready, "R11 idle", {30'b0, code_we, ready}, 32'h1);
    end
  end

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_req = 1; reg_we = 0; reg_addr = a;
    #3 chk(reg_rdata == exp, tag, reg_rdata, exp);
    @(negedge clk); reg_req = 0;
  endtask

  task automatic ua_wr(input logic [UAW-1:0] a, input logic [31:0] d);
    @(negedge clk); ua_req = 1; ua_we = 1; ua_addr = a; ua_wdata = d;
    @(negedge clk); ua_req = 0; ua_we = 0;
  endtask

  task automatic ua_rd(input logic [UAW-1:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk); ua_req = 1; ua_we = 0; ua_addr = a;
    #3 exp = (a[1:0] == 0 && a < UW * 4) ? m_ua[a / 4] : 32'h0;
    chk(ua_rdata == exp, tag, ua_rdata, exp);
    @(negedge clk); ua_req = 0;
  endtask

  task automatic wait_idle();
    while (q.size() > 0 || m_pend || m_clr_now) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    reg_rd(12'h400, 32'h1, "R1 ready after reset");
    reg_rd(12'h504, 32'h0, "R1 config after reset");
    chk(cfg == m_cfg, "R1 cfg_o", {30'b0, cfg}, {30'b0, m_cfg});
    ua_rd(10'h000, "R1 user word 0");
    ua_rd(10'h0FC, "R1 user word 63");
    // R3 config keeps two bits
    reg_wr(12'h504, 32'hFFFF_FFFF);
    reg_rd(12'h504, 32'h3, "R3 config masked");
    reg_wr(12'h504, 32'h6);
    reg_rd(12'h504, 32'h2, "R3 config readback");
    chk(cfg == 2'b10, "R3 cfg_o", {30'b0, cfg}, 32'h2);
    // R9 unknown offsets
    reg_rd(12'h500, 32'h0, "R9 unknown read");
    reg_wr(12'h500, 32'h1);
    reg_wr(12'h518, 32'h1);
    reg_rd(12'h504, 32'h2, "R9 unknown write no effect");
    reg_rd(12'h400, 32'h1, "R2 status idle");
    // R4 page erase via both registers, address aligned down
    reg_wr(12'h508, 32'h0000_01A3);
    wait_idle();
    reg_wr(12'h510, 32'h0000_03FF);
    wait_idle();
    reg_rd(12'h400, 32'h1, "R4 ready after page erase");
    // R5 out-of-range page addresses
    reg_wr(12'h508, 32'h0000_0400);
    reg_rd(12'h400, 32'h1, "R5 out of range ignored");
    reg_wr(12'h510, 32'hFFFF_FFFF);
    reg_rd(12'h400, 32'h1, "R5 top address ignored");
    // R8 user area access rules
    ua_wr(10'h014, 32'hA5A5_0005);
    ua_rd(10'h014, "R8 aligned write/read");
    ua_wr(10'h015, 32'h0);
    ua_rd(10'h014, "R8 unaligned write ignored");
    ua_rd(10'h015, "R8 unaligned read zero");
    ua_wr(10'h100, 32'h1234);
    ua_rd(10'h000, "R8 out of range write ignored");
    ua_rd(10'h100, "R8 out of range read zero");
    // R7 user area erase
    reg_wr(12'h514, 32'h3);
    ua_rd(10'h014, "R7 non-1 value ignored");
    reg_wr(12'h514, 32'h1);
    wait_idle();
    ua_rd(10'h014, "R7 user erase clears");
    // R6 erase all
    ua_wr(10'h020, 32'h0000_0011);
    reg_wr(12'h50C, 32'h2);
    ua_rd(10'h020, "R6 non-1 value ignored");
    reg_wr(12'h50C, 32'h1);
    // R10 busy: status reads 0, reads work, commands dropped
    reg_rd(12'h400, 32'h0, "R10 status busy");
    reg_wr(12'h508, 32'h0);
    reg_wr(12'h514, 32'h1);
    reg_rd(12'h504, 32'h2, "R10 read during erase");
    wait_idle();
    ua_rd(10'h020, "R6 erase all clears user area");
    reg_rd(12'h400, 32'h1, "R2 status ready after erase all");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule